// File: doc/BRIEF.md
# Misaligned Load/Store Bus Splitter

This block sits between the pipeline's load/store stage and the data-side bus. It takes one memory access (a byte address, a size of byte, halfword or word, a read/write flag, a signed-load flag and store data) and turns it into word-aligned bus transactions with byte enables. If the access fits inside one bus word, it issues one transaction. If a word access is not word-aligned, or a halfword access spans two words, it issues two transactions and joins the returned bytes into one result.

The bus side uses a request/grant handshake with a separate read-valid response. Every transaction gets exactly one response, and that response comes at least one cycle after its grant. On the pipeline side, the block accepts a new access only while it is idle. When an access is complete it pulses `doneValid` for one cycle, with the extended load value on `doneData`. For stores, `doneData` is zero.

Top module: `lsuSplitter`

## Requirements
- R1: An access whose bytes all lie in one 4-byte word is issued as exactly one bus transaction, to the word address (the access address with bits [1:0] cleared).
- R2: A word access (`reqSize`=2) at an address with a non-zero low two bits is issued as two transactions: the lower word address first, then that address plus 4.
- R3: A halfword access (`reqSize`=1) at an address whose low two bits are 3 is issued as two transactions. A halfword at offsets 0, 1 or 2 is issued as one.
- R4: Bit k of `busBe` is set exactly when byte lane k of that transaction belongs to the access. Lane k is the byte at word address + k, so the lanes are little-endian.
- R5: For stores, each byte of `reqWdata` goes out on the lane of its target address. Byte i of the data (bits 8i+7:8i) is written to address + i. When an access is split, each store byte appears in the transaction whose enabled lanes cover its address.
- R6: For loads, the returned bytes are assembled in address order, so address + i becomes result byte i. A byte (`reqSize`=0) or halfword is then sign-extended when `reqSigned` is 1 and zero-extended when it is 0. Store completions report zero.
- R7: With the bus granting at once and responding one cycle after the grant, `doneValid` rises on the 2nd rising edge after acceptance for a single-transaction access and on the 3rd for a split access. `doneValid` lasts one cycle.
- R8: While `busReq` is high and `busGnt` is low, the request stays asserted and `busAddr`, `busBe` and `busWdata` hold their values.
- R9: `reqReady` is high only when no access is in flight. `reqValid` and the request fields are ignored while `reqReady` is low.
- R10: After reset, `busReq` and `doneValid` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request from the pipeline |
| reqReady | output | 1 | Block is idle and will accept |
| reqAddr | input | 32 | Byte address of the access |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSigned | input | 1 | Sign-extend a load |
| reqWdata | input | 32 | Store data, right-justified |
| busReq | output | 1 | Bus transaction request |
| busGnt | input | 1 | Bus grant |
| busAddr | output | 32 | Word-aligned bus address |
| busWe | output | 1 | Bus write enable |
| busBe | output | 4 | Bus byte enables |
| busWdata | output | 32 | Bus write data, lane-aligned |
| busRvalid | input | 1 | Bus response valid |
| busRdata | input | 32 | Bus read data |
| doneValid | output | 1 | Access completed (one-cycle pulse) |
| doneData | output | 32 | Extended load result, zero for stores |

## Verification
A request is accepted on a rising edge. Its first bus transaction is visible before the next edge, and `doneValid` with the result follows two edges later for one transaction or three edges later for a split access. The bench counts falling edges from the acceptance edge and expects completion at count 3 or 4. It reads `doneData` at that same sampling point. Its bus model logs each granted transaction and responds on the following edge. The stall test and the ignore test check for correctness rather than exact cycles, because the grant delay stretches the count by the number of stalled cycles.

// File: rtl/lsuSplitPkg.sv
`timescale 1ns/1ps
package lsuSplitPkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ISSUE_LO = 2'd1,
    ST_ISSUE_HI = 2'd2,
    ST_DRAIN    = 2'd3
  } splitStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;  // latch the incoming access
    logic selHigh;     // address the second (upper) word
    logic captureLow;  // keep the first response of a split access
    logic finish;      // final response present: register the result
  } ctrlStrobeT;

endpackage

// File: rtl/lsuSplitCtrl.sv
`timescale 1ns/1ps
module lsuSplitCtrl
  import lsuSplitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busGnt,
  input  logic       busRvalid,
  input  logic       isSplit,
  output logic       reqReady,
  output logic       busReq,
  output ctrlStrobeT strb,
  output logic       doneValid
);

  splitStateE stateQ, stateD;
  logic       gotFirstQ;

  always_comb begin
    reqReady        = (stateQ == ST_IDLE);
    busReq          = (stateQ == ST_ISSUE_LO) || (stateQ == ST_ISSUE_HI);
    strb.captureReq = (stateQ == ST_IDLE) && reqValid;
    strb.selHigh    = (stateQ == ST_ISSUE_HI);
    strb.captureLow = busRvalid && isSplit && !gotFirstQ;
    strb.finish     = busRvalid && (!isSplit || gotFirstQ);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (reqValid) stateD = ST_ISSUE_LO;
      ST_ISSUE_LO: if (busGnt) stateD = isSplit ? ST_ISSUE_HI : ST_DRAIN;
      ST_ISSUE_HI: if (busGnt) stateD = ST_DRAIN;
      ST_DRAIN:    if (strb.finish) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      gotFirstQ <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      stateQ    <= stateD;
      doneValid <= strb.finish;
      if (strb.captureReq)      gotFirstQ <= 1'b0;
      else if (strb.captureLow) gotFirstQ <= 1'b1;
    end
  end

endmodule

// File: rtl/lsuSplitData.sv
`timescale 1ns/1ps
module lsuSplitData
  import lsuSplitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              isSplit,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W/8-1:0] busBe,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] doneData
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic              writeQ, signedQ;
  logic [DATA_W-1:0] wdataQ, lowQ;

  logic [OFF_W-1:0]   offset;
  logic [2*LANES-1:0] baseMask, spanMask;
  logic [ADDR_W-1:0]  wordBase;
  logic [2*DATA_W-1:0] dblWdata, joined;
  logic [DATA_W-1:0]  lowSel, raw, extended;

  assign offset   = addrQ[OFF_W-1:0];
  assign wordBase = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // Lanes touched by the access, over a two-word window
  always_comb begin
    baseMask = '0;
    unique case (sizeQ)
      2'd0:    baseMask[0]       = 1'b1;
      2'd1:    baseMask[1:0]     = 2'b11;
      default: baseMask[LANES-1:0] = '1;
    endcase
    spanMask = baseMask << offset;
  end

  assign isSplit = |spanMask[2*LANES-1:LANES];

  // Transaction side
  assign dblWdata = {wdataQ, wdataQ} << {offset, 3'b000};
  assign busWe    = writeQ;
  assign busWdata = dblWdata[2*DATA_W-1:DATA_W];
  assign busAddr  = strb.selHigh ? wordBase + ADDR_W'(LANES) : wordBase;
  assign busBe    = strb.selHigh ? spanMask[2*LANES-1:LANES] : spanMask[LANES-1:0];

  // Response assembly in address order
  assign lowSel = isSplit ? lowQ : busRdata;
  assign joined = {busRdata, lowSel} >> {offset, 3'b000};
  assign raw    = joined[DATA_W-1:0];

  always_comb begin
    unique case (sizeQ)
      2'd0:    extended = {{(DATA_W-8){signedQ & raw[7]}}, raw[7:0]};
      2'd1:    extended = {{(DATA_W-16){signedQ & raw[15]}}, raw[15:0]};
      default: extended = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      writeQ   <= 1'b0;
      signedQ  <= 1'b0;
      wdataQ   <= '0;
      lowQ     <= '0;
      doneData <= '0;
    end else begin
      if (strb.captureReq) begin
        addrQ   <= reqAddr;
        sizeQ   <= reqSize;
        writeQ  <= reqWrite;
        signedQ <= reqSigned;
        wdataQ  <= reqWdata;
      end
      if (strb.captureLow) lowQ <= busRdata;
      if (strb.finish)     doneData <= writeQ ? '0 : extended;
    end
  end

endmodule

// File: rtl/lsuSplitter.sv
`timescale 1ns/1ps
module lsuSplitter
  import lsuSplitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W/8-1:0] busBe,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busRvalid,
  input  logic [DATA_W-1:0] busRdata,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);

  ctrlStrobeT strb;
  logic       isSplit;

  lsuSplitCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busGnt    (busGnt),
    .busRvalid (busRvalid),
    .isSplit   (isSplit),
    .reqReady  (reqReady),
    .busReq    (busReq),
    .strb      (strb),
    .doneValid (doneValid)
  );

  lsuSplitData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqSigned (reqSigned),
    .reqWdata  (reqWdata),
    .busRdata  (busRdata),
    .isSplit   (isSplit),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busBe     (busBe),
    .busWdata  (busWdata),
    .doneData  (doneData)
  );

endmodule

// File: rtl/lsuSplitChecker.sv
`timescale 1ns/1ps
module lsuSplitChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W/8-1:0] busBe,
  input logic [DATA_W-1:0] busWdata,
  input logic              reqReady,
  input logic              doneValid
);

  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busAddr[1:0] == 2'b00); // R1

  AST_SECOND_NEXT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && $past(busReq && busGnt) |-> busAddr == $past(busAddr) + ADDR_W'(4)); // R2

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busBe != '0); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R7

  AST_HOLD_UNGRANTED: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |=> busReq && $stable(busAddr) && $stable(busBe) && $stable(busWdata)); // R8

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReq); // R9

endmodule

bind lsuSplitter lsuSplitChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busGnt    (busGnt),
  .busAddr   (busAddr),
  .busBe     (busBe),
  .busWdata  (busWdata),
  .reqReady  (reqReady),
  .doneValid (doneValid)
);

// File: tb/lsuSplitter_bench.sv
`timescale 1ns/1ps
module lsuSplitter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqSigned = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        busReq, busGnt, busWe;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busBe;
  logic        busRvalid;
  logic [31:0] busRdata;
  logic        doneValid;
  logic [31:0] doneData;
  logic        holdGnt = 1'b0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lsuSplitter u_lsuSplitter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqSigned(reqSigned), .reqWdata(reqWdata), .busReq(busReq),
    .busGnt(busGnt), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRvalid(busRvalid), .busRdata(busRdata),
    .doneValid(doneValid), .doneData(doneData)
  );

  // Bus model: grants unless held off and responds one edge after the grant
  logic [7:0]  mem [64];
  logic [7:0]  refMem [64];
  logic [31:0] logAddr [8];
  logic [3:0]  logBe [8];
  logic        logWe [8];
  int          txnTotal = 0;
  int          slvA;

  assign busGnt = busReq && !holdGnt;

  always @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
      for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 131);
    end else begin
      busRvalid <= busReq && busGnt;
      if (busReq && busGnt) begin
        slvA = int'({busAddr[5:2], 2'b00});
        busRdata <= {mem[slvA+3], mem[slvA+2], mem[slvA+1], mem[slvA]};
        if (busWe)
          for (int k = 0; k < 4; k++)
            if (busBe[k]) mem[slvA+k] = busWdata[8*k +: 8];
        logAddr[txnTotal % 8] = busAddr;
        logBe[txnTotal % 8]   = busBe;
        logWe[txnTotal % 8]   = busWe;
        txnTotal = txnTotal + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refLoad(input logic [31:0] a, input logic [1:0] sz,
                                          input logic sgn);
    logic [31:0] v;
    int base = int'(a[5:0]);
    v = {refMem[(base+3)%64], refMem[(base+2)%64], refMem[(base+1)%64], refMem[base]};
    case (sz)
      2'd0:    return {{24{sgn & v[7]}}, v[7:0]};
      2'd1:    return {{16{sgn & v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic int sizeBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic refStore(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    for (int i = 0; i < sizeBytes(sz); i++) refMem[(int'(a[5:0]) + i) % 64] = d[8*i +: 8];
  endtask

  // Issue one access; returns the result and the falling-edge count to completion
  task automatic runOp(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic sgn, input logic [31:0] wd,
                       output logic [31:0] res, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr;
    reqSigned = sgn; reqWdata = wd;
    @(posedge clk);
    lat = 0;
    res = '0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (doneValid) begin
        res = doneData;
        break;
      end
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic        sgn;
    logic [31:0] wdata;
    logic [1:0]  nTxn;
    logic [3:0]  be0;
    logic [3:0]  be1;
  } vecT;

  localparam vecT VECS [14] = '{
    '{32'h10, 2'd2, 1'b0, 1'b1, 32'h0,        2'd1, 4'hF, 4'h0},
    '{32'h12, 2'd1, 1'b0, 1'b0, 32'h0,        2'd1, 4'hC, 4'h0},
    '{32'h13, 2'd0, 1'b0, 1'b1, 32'h0,        2'd1, 4'h8, 4'h0},
    '{32'h11, 2'd1, 1'b0, 1'b1, 32'h0,        2'd1, 4'h6, 4'h0},
    '{32'h13, 2'd1, 1'b0, 1'b1, 32'h0,        2'd2, 4'h8, 4'h1},
    '{32'h15, 2'd2, 1'b0, 1'b1, 32'h0,        2'd2, 4'hE, 4'h1},
    '{32'h16, 2'd2, 1'b0, 1'b0, 32'h0,        2'd2, 4'hC, 4'h3},
    '{32'h17, 2'd2, 1'b0, 1'b0, 32'h0,        2'd2, 4'h8, 4'h7},
    '{32'h20, 2'd2, 1'b1, 1'b0, 32'h11223344, 2'd1, 4'hF, 4'h0},
    '{32'h21, 2'd2, 1'b1, 1'b0, 32'hA1B2C3D4, 2'd2, 4'hE, 4'h1},
    '{32'h27, 2'd1, 1'b1, 1'b0, 32'h0000BEEF, 2'd2, 4'h8, 4'h1},
    '{32'h2A, 2'd0, 1'b1, 1'b0, 32'h0000005A, 2'd1, 4'h4, 4'h0},
    '{32'h2F, 2'd1, 1'b1, 1'b0, 32'h00007E81, 2'd2, 4'h8, 4'h1},
    '{32'h0E, 2'd1, 1'b0, 1'b0, 32'h0,        2'd1, 4'hC, 4'h0}
  };

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] res, expRes;
    int lat, base;
    bit memOk;

    for (int i = 0; i < 64; i++) refMem[i] = 8'(i * 37 + 131);
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!busReq, "R10 busReq after reset", 32'(busReq), 32'h0);
    check(!doneValid, "R10 doneValid after reset", 32'(doneValid), 32'h0);
    check(reqReady, "R10 reqReady after reset", 32'(reqReady), 32'h1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[v]) begin
      expRes = VECS[v].wr ? 32'h0 : refLoad(VECS[v].addr, VECS[v].size, VECS[v].sgn);
      base = txnTotal;
      runOp(VECS[v].addr, VECS[v].size, VECS[v].wr, VECS[v].sgn, VECS[v].wdata, res, lat);
      if (VECS[v].wr) refStore(VECS[v].addr, VECS[v].size, VECS[v].wdata);
      // R1 R2 R3: transaction count and order
      check(txnTotal - base == int'(VECS[v].nTxn), "R1/R2/R3 transaction count",
            32'(txnTotal - base), 32'(VECS[v].nTxn));
      check(logAddr[base % 8] == {VECS[v].addr[31:2], 2'b00}, "R1 first word address",
            logAddr[base % 8], {VECS[v].addr[31:2], 2'b00});
      check(logBe[base % 8] == VECS[v].be0, "R4 first byte enables",
            32'(logBe[base % 8]), 32'(VECS[v].be0));
      check(logWe[base % 8] == VECS[v].wr, "R5 write flag",
            32'(logWe[base % 8]), 32'(VECS[v].wr));
      if (VECS[v].nTxn == 2'd2) begin
        check(logAddr[(base+1) % 8] == logAddr[base % 8] + 32'd4, "R2 second word address",
              logAddr[(base+1) % 8], logAddr[base % 8] + 32'd4);
        check(logBe[(base+1) % 8] == VECS[v].be1, "R4 second byte enables",
              32'(logBe[(base+1) % 8]), 32'(VECS[v].be1));
      end
      check(lat == int'(VECS[v].nTxn) + 2, "R7 completion latency",
            32'(lat), 32'(int'(VECS[v].nTxn) + 2));
      check(res == expRes, "R6 result data", res, expRes);
      if (VECS[v].wr) begin
        memOk = 1'b1;
        for (int i = 0; i < 64; i++) if (mem[i] != refMem[i]) memOk = 1'b0;
        check(memOk, "R5 store lands on its bytes", 32'(memOk), 32'h1);
      end
    end

    // R6: zero and sign extension of the same negative byte (0x83 at address 0)
    runOp(32'h0, 2'd0, 1'b0, 1'b0, 32'h0, res, lat);
    check(res == 32'h00000083, "R6 unsigned byte zero-extended", res, 32'h00000083);
    runOp(32'h0, 2'd0, 1'b0, 1'b1, 32'h0, res, lat);
    check(res == 32'hFFFFFF83, "R6 signed byte sign-extended", res, 32'hFFFFFF83);

    // R8: grant held off on a split load; request must persist and result still correct
    holdGnt = 1'b1;
    expRes = refLoad(32'h19, 2'd2, 1'b0);
    base = txnTotal;
    fork
      runOp(32'h19, 2'd2, 1'b0, 1'b0, 32'h0, res, lat);
      begin
        repeat (2) @(negedge clk);
        repeat (3) begin
          @(negedge clk);
          check(busReq && busAddr == 32'h18, "R8 request held while ungranted",
                busAddr, 32'h18);
        end
        holdGnt = 1'b0;
      end
    join
    check(res == expRes, "R8 stalled split result", res, expRes);
    check(txnTotal - base == 2, "R8 stalled split count", 32'(txnTotal - base), 32'd2);

    // R9: new request while busy is ignored
    expRes = refLoad(32'h05, 2'd2, 1'b0);
    base = txnTotal;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h05; reqSize = 2'd2; reqWrite = 1'b0; reqSigned = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqAddr = 32'h31; reqSize = 2'd0; reqWrite = 1'b1; reqWdata = 32'hFF;
    check(!reqReady, "R9 not ready while busy", 32'(reqReady), 32'h0);
    @(negedge clk);
    check(!reqReady, "R9 not ready while busy", 32'(reqReady), 32'h0);
    reqValid = 1'b0;
    res = '0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (doneValid) begin res = doneData; break; end
    end
    check(res == expRes, "R9 result unaffected by ignored request", res, expRes);
    repeat (3) @(negedge clk);
    check(txnTotal - base == 2, "R9 no extra transactions", 32'(txnTotal - base), 32'd2);
    check(mem[49] == refMem[49], "R9 ignored store did not write",
          32'(mem[49]), 32'(refMem[49]));
    check(!doneValid && reqReady, "R7 done is a single pulse", 32'(doneValid), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule